// File: doc/BRIEF.md
# Multi-channel prescaled event timer

This peripheral holds four independent countdown channels and one free-running 32-bit up-counter behind a small word-addressed register port. A prescaler divides the system clock down to a one-microsecond strobe. Three cascaded divide-by-ten stages turn that strobe into 10 µs, 100 µs and 1 ms strobes. Each countdown channel picks one of these four rates. The up-counter picks one of them or the raw system clock.

Software writes a load value into a channel register, then sets the channel's enable and mode bits in the shared control word. When a channel reaches zero on a tick, it raises a one-cycle interrupt pulse. It then either reloads its stored value (periodic) or drops its own enable bit (one-shot). Writing N−1 gives a periodic event every N ticks. The up-counter runs from reset and serves as a monotonic time reference. Reading its register returns the live count.

Top module: `tmr_block`

## Requirements
- R1: After reset, the control word, all four channel counts, the up-counter value and all interrupt outputs read as zero.
- R2: The 1 µs strobe occurs once every US_DIV system clocks. Each further rate (10 µs, 100 µs, 1 ms) is RATIO times slower than the one before. An up-counter on code 1, 2, 3 or 4 therefore advances by exactly K over K·US_DIV·RATIO^(code−1) clocks.
- R3: The up-counter sits at byte offset 0x14. Its rate code is control bits 10:8, where code 0 means every system clock. Codes 5, 6 and 7 hold the counter still. A write sets the count, which then advances and wraps modulo 2^32.
- R4: A channel with enable set and mode bit 1 (periodic) raises an interrupt every (V+1)·P clocks, where V is the written load value and P is the period of its tick. The channel rate field has 2 bits per channel: A at 1:0, B at 3:2, C at 5:4, D at 7:6. Code 0 selects 1 µs, 1 selects 10 µs, 2 selects 100 µs and 3 selects 1 ms.
- R5: Every interrupt is a single-cycle pulse on irq_o. Bit 0 belongs to A and bit 3 belongs to D.
- R6: A channel with enable set and mode bit 0 (one-shot) raises exactly one interrupt. At the same time it clears its own enable bit and leaves every other control bit unchanged. Its count then stays at zero.
- R7: A channel whose enable bit is 0 keeps its count and raises no interrupt.
- R8: Reading a channel register returns its live count, which drops by one on each selected tick while the channel is enabled.
- R9: In the control word at offset 0x00, bits 19:16 are the enables for A–D and bits 15:12 are the modes for A–D. Bit 11 and bits 31:20 always read as zero.
- R10: The channel registers sit at offsets 0x04, 0x08, 0x0C and 0x10 for A–D and are 16 bits wide, so the upper 16 bits of a write are dropped and read as zero. Any undecoded offset reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address; bits ADDR_W-1:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 4 | Per-channel expiry pulses, bit 0 = channel A |

## Verification
The bench builds the block with US_DIV = 2 and RATIO = 10. The 1 ms strobe then arrives every 2000 clocks, so all four channel rates and all eight up-counter codes can be swept inside the cycle budget. Four rounds rotate rate codes and load values across the channels, so every channel runs at every rate while the others run at different rates. With these small values the wrap of the up-counter, one-shot self-clearing and the hold of a disabled channel all show up within a few dozen cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCH  = 4;
    localparam int CW   = 16;
    localparam int EW   = 32;
    localparam int NRATE = 4;

    typedef struct packed {
        logic [NCH-1:0]      en;
        logic [NCH-1:0]      mode;
        logic [2:0]          esel;
        logic [NCH-1:0][1:0] csel;
    } ctrl_t;

    typedef enum logic [2:0] {
        W_CTRL = 3'd0,
        W_CHA  = 3'd1,
        W_CHB  = 3'd2,
        W_CHC  = 3'd3,
        W_CHD  = 3'd4,
        W_UP   = 3'd5
    } word_e;

    function automatic logic [31:0] ctrl_pack(ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[19:16] = c.en;
        w[15:12] = c.mode;
        w[10:8]  = c.esel;
        w[7:0]   = c.csel;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [31:0] w);
        ctrl_t c;
        c.en   = w[19:16];
        c.mode = w[15:12];
        c.esel = w[10:8];
        c.csel = w[7:0];
        return c;
    endfunction

    function automatic logic chan_tick(logic [1:0] sel, logic [NRATE-1:0] tk);
        return tk[sel];
    endfunction

    function automatic logic up_tick(logic [2:0] sel, logic [NRATE-1:0] tk);
        logic t;
        case (sel)
            3'd0:    t = 1'b1;
            3'd1:    t = tk[0];
            3'd2:    t = tk[1];
            3'd3:    t = tk[2];
            3'd4:    t = tk[3];
            default: t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int US_DIV = 50,
    parameter int RATIO  = 10,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES:0]   tick_o
);
    localparam int PW = (US_DIV > 1) ? $clog2(US_DIV) : 1;
    localparam int RW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic [PW-1:0] pre_q;
    logic          pre_wrap;

    assign pre_wrap  = (pre_q == PW'(US_DIV - 1));
    assign tick_o[0] = pre_wrap;

    always_ff @(posedge clk) begin
        if (rst || pre_wrap) pre_q <= '0;
        else                 pre_q <= pre_q + 1'b1;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [RW-1:0] dec_q;
        logic          dec_last;

        assign dec_last    = (dec_q == RW'(RATIO - 1));
        assign tick_o[s+1] = tick_o[s] && dec_last;

        always_ff @(posedge clk) begin
            if (rst)             dec_q <= '0;
            else if (tick_o[s])  dec_q <= dec_last ? '0 : dec_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_down_chan.sv
module tmr_down_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          periodic,
    input  logic          tick,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] count_o,
    output logic          expire_o,
    output logic          irq_o
);
    logic [CW-1:0] reload_q;
    logic [CW-1:0] cnt_q;

    assign expire_o = en && tick && (cnt_q == '0) && !ld;
    assign count_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
            irq_o    <= 1'b0;
        end else begin
            irq_o <= expire_o;
            if (ld) begin
                cnt_q    <= ld_val;
                reload_q <= ld_val;
            end else if (expire_o) begin
                if (periodic) cnt_q <= reload_q;
            end else if (en && tick) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_up_count.sv
module tmr_up_count #(
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          ld,
    input  logic [EW-1:0] ld_val,
    output logic [EW-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst)       count_o <= '0;
        else if (ld)   count_o <= ld_val;
        else if (tick) count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/tmr_block.sv
module tmr_block
    import tmr_pkg::*;
#(
    parameter int US_DIV = 50,
    parameter int RATIO  = 10,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    irq_o
);
    localparam int IW = ADDR_W - 2;

    logic [IW-1:0]             widx;
    ctrl_t                     ctrl_q;
    logic                      ctrl_wr;
    logic [NRATE-1:0]          tick_vec;
    logic [NCH-1:0][CW-1:0]    chan_cnt;
    logic [NCH-1:0]            chan_ld;
    logic [NCH-1:0]            chan_exp;
    logic [EW-1:0]             e_cnt;
    logic                      e_ld;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign ctrl_wr = bus_we && (widx == IW'(W_CTRL));
    assign e_ld    = bus_we && (widx == IW'(W_UP));

    tmr_tick_gen #(
        .US_DIV (US_DIV),
        .RATIO  (RATIO),
        .STAGES (NRATE - 1)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick_vec)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign chan_ld[i] = bus_we && (widx == IW'(i + 1));

        tmr_down_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (ctrl_q.en[i]),
            .periodic (ctrl_q.mode[i]),
            .tick     (chan_tick(ctrl_q.csel[i], tick_vec)),
            .ld       (chan_ld[i]),
            .ld_val   (bus_wdata[CW-1:0]),
            .count_o  (chan_cnt[i]),
            .expire_o (chan_exp[i]),
            .irq_o    (irq_o[i])
        );
    end

    tmr_up_count #(.EW(EW)) u_up (
        .clk     (clk),
        .rst     (rst),
        .tick    (up_tick(ctrl_q.esel, tick_vec)),
        .ld      (e_ld),
        .ld_val  (bus_wdata[EW-1:0]),
        .count_o (e_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_unpack(bus_wdata);
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (chan_exp[i] && !ctrl_q.mode[i]) ctrl_q.en[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (widx == IW'(W_CTRL)) bus_rdata = ctrl_pack(ctrl_q);
        if (widx == IW'(W_UP))   bus_rdata = e_cnt;
        for (int i = 0; i < NCH; i++) begin
            if (widx == IW'(i + 1)) bus_rdata = {{(32-CW){1'b0}}, chan_cnt[i]};
        end
    end

endmodule

// File: rtl/tmr_block_chk.sv
module tmr_block_chk
    import tmr_pkg::*;
#(
    parameter int US_DIV = 50
) (
    input logic                   clk,
    input logic                   rst,
    input ctrl_t                  ctrl_q,
    input logic                   ctrl_wr,
    input logic [NRATE-1:0]       tick_vec,
    input logic [NCH-1:0][CW-1:0] chan_cnt,
    input logic [NCH-1:0]         chan_ld,
    input logic [EW-1:0]          e_cnt,
    input logic                   e_ld,
    input logic [NCH-1:0]         irq_o
);
    for (genvar s = 0; s < NRATE - 1; s++) begin : g_nest
        p_tick_nest_r2: assert property (@(posedge clk) disable iff (rst)
            tick_vec[s+1] |-> tick_vec[s]);
    end

    p_up_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.esel > 3'd4 && !e_ld && !ctrl_wr) |=> $stable(e_cnt));

    p_up_step_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.esel == 3'd0 && !e_ld && !ctrl_wr) |=> (e_cnt == $past(e_cnt) + 1'b1));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (US_DIV > 1) begin : g_pulse
            p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
                irq_o[i] |=> !irq_o[i]);
        end

        p_oneshot_clear_r6: assert property (@(posedge clk) disable iff (rst)
            (irq_o[i] && !ctrl_q.mode[i] && !$past(ctrl_wr)) |-> !ctrl_q.en[i]);

        p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q.en[i] |=> !irq_o[i]);

        p_off_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_q.en[i] && !chan_ld[i] && !ctrl_wr) |=> $stable(chan_cnt[i]));
    end

endmodule

bind tmr_block tmr_block_chk #(.US_DIV(US_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl_q   (ctrl_q),
    .ctrl_wr  (ctrl_wr),
    .tick_vec (tick_vec),
    .chan_cnt (chan_cnt),
    .chan_ld  (chan_ld),
    .e_cnt    (e_cnt),
    .e_ld     (e_ld),
    .irq_o    (irq_o)
);

// File: tb/tb_tmr_block.sv
module tb_tmr_block;
    localparam int CLK_PERIOD = 10;
    localparam int US_DIV     = 2;
    localparam int RATIO      = 10;
    localparam int ADDR_W     = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [3:0]        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int dbl = 0;
    int irq_cnt [4];
    int last_t  [4];
    int prev_t  [4];
    bit prev_hi [4];

    tmr_block #(.US_DIV(US_DIV), .RATIO(RATIO), .ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int i = 0; i < 4; i++) begin
            irq_cnt[i] = 0; last_t[i] = 0; prev_t[i] = 0; prev_hi[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                if (irq[i]) begin
                    irq_cnt[i]++;
                    prev_t[i] = last_t[i];
                    last_t[i] = cyc;
                    if (prev_hi[i]) dbl++;
                end
                prev_hi[i] = irq[i];
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycw(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int rate_period(int code);
        int p;
        p = US_DIV;
        for (int j = 0; j < code; j++) p = p * RATIO;
        return p;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r1, r2, w;
        int code [4];
        int val  [4];
        int base [4];
        int t;
        bit busy;

        // R1: state while reset is held
        cycw(3);
        rd(5'h00, r1); chk("R1 ctrl", r1, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(ADDR_W'(4*(i+1)), r1); chk("R1 channel", r1, 32'h0);
        end
        rd(5'h14, r1); chk("R1 up-counter", r1, 32'h0);
        chk("R1 irq", {28'h0, irq}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        cycw(2);

        // R9: unused control bits read zero
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, r1); chk("R9 ctrl mask", r1, 32'h000F_F7FF);
        wr(5'h00, 32'h0);

        // R10: 16-bit channel width and undecoded offsets
        wr(5'h0C, 32'h0001_2345);
        rd(5'h0C, r1); chk("R10 channel width", r1, 32'h0000_2345);
        rd(5'h18, r1); chk("R10 undecoded", r1, 32'h0);

        // R2: up-counter rate per code
        for (int c = 0; c <= 4; c++) begin
            int pc;
            pc = (c == 0) ? 1 : rate_period(c - 1);
            wr(5'h00, 32'(c) << 8);
            rd(5'h14, r1);
            cycw(2 * pc);
            rd(5'h14, r2);
            chk("R2 up-counter rate", r2 - r1, 32'd2);
        end
        // R3: codes 5..7 hold
        for (int c = 5; c <= 7; c++) begin
            wr(5'h00, 32'(c) << 8);
            rd(5'h14, r1);
            cycw(50);
            rd(5'h14, r2);
            chk("R3 up-counter hold", r2, r1);
        end
        // R3: load and wrap
        wr(5'h00, 32'h0);
        wr(5'h14, 32'hFFFF_FFFE);
        rd(5'h14, r1); chk("R3 up-counter load", r1, 32'hFFFF_FFFE);
        cycw(3);
        rd(5'h14, r1); chk("R3 up-counter wrap", r1, 32'h0000_0001);

        // R8: live countdown
        wr(5'h04, 32'd100);
        wr(5'h00, 32'h0001_0000);
        rd(5'h04, r1);
        cycw(10 * US_DIV);
        rd(5'h04, r2);
        chk("R8 countdown step", r1 - r2, 32'd10);
        wr(5'h00, 32'h0);

        // R6: one-shot on A, B periodic at 1 ms untouched
        wr(5'h04, 32'd5);
        wr(5'h08, 32'h0000_FFFE);
        base[0] = irq_cnt[0];
        wr(5'h00, 32'h0003_200C);
        cycw(60);
        chk("R6 single pulse", 32'(irq_cnt[0] - base[0]), 32'd1);
        rd(5'h00, r1); chk("R6 enable self-clear", r1, 32'h0002_200C);
        rd(5'h04, r1); chk("R6 count stays zero", r1, 32'h0);
        wr(5'h00, 32'h0);

        // R7: disabled channel holds and stays quiet
        wr(5'h04, 32'd0);
        wr(5'h00, 32'h0001_1000);
        cycw(10);
        wr(5'h00, 32'h0);
        cycw(2);
        base[0] = irq_cnt[0];
        rd(5'h04, r1);
        cycw(40);
        rd(5'h04, r2);
        chk("R7 count held", r2, r1);
        chk("R7 no irq", 32'(irq_cnt[0] - base[0]), 32'd0);

        // R4: periodic sweep, each channel through every rate
        for (int k = 0; k < 4; k++) begin
            wr(5'h00, 32'h0);
            cycw(2);
            w = 32'h000F_F000;
            for (int i = 0; i < 4; i++) begin
                code[i] = (i + k) % 4;
                val[i]  = (i + 2 * k) % 3;
                wr(ADDR_W'(4*(i+1)), 32'(val[i]));
                w = w | (32'(code[i]) << (2 * i));
            end
            for (int i = 0; i < 4; i++) base[i] = irq_cnt[i];
            wr(5'h00, w);
            t = 0;
            busy = 1'b1;
            while (busy && t < 40000) begin
                cycw(1);
                t++;
                busy = 1'b0;
                for (int i = 0; i < 4; i++)
                    if (irq_cnt[i] < base[i] + 3) busy = 1'b1;
            end
            for (int i = 0; i < 4; i++)
                chk("R4 periodic interval", 32'(last_t[i] - prev_t[i]),
                    32'((val[i] + 1) * rate_period(code[i])));
        end
        wr(5'h00, 32'h0);
        cycw(2);

        // R5: no interrupt lasted two cycles
        chk("R5 single-cycle pulse", 32'(dbl), 32'd0);

        summary();
        $finish;
    end

endmodule